// File: doc/BRIEF.md
# Prioritised Interrupt Request and Vector Sequencer

This block collects interrupt requests from two sources: a timer that signals each reload and an external pin whose edges are detected upstream. It holds one pending latch per source and applies a local enable to each. A global interrupt-enable bit gates both. When a request is accepted, the block raises a registered request to the CPU. When the CPU answers with a grant strobe, the block runs a fixed four-cycle vectoring sequence. The sequence is a settling cycle, then a cycle that drives the low vector byte and tells the CPU to save its return address, then a cycle that drives the high vector byte, and finally a cycle that clears the serviced latch and the global enable.

The two latches follow different clearing rules. The timer latch records a reload even while its local enable is off, and it keeps that record until the request is serviced or the timer port is rewritten. The external latch only records an edge while its enable is on, and it is lost as soon as that enable drops. When both sources are pending, the timer is serviced first. The source is chosen on the grant cycle and then held for the whole sequence.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A timer reload event (`tmr_reload_i`) sets the timer latch whether `tmr_irq_en_i` is high or low. The timer latch only contributes to a request while `tmr_irq_en_i` is high.
- R2: The timer latch is cleared only in two ways: at the end of its own service sequence, or by a pulse on `tmr_port_wr_i`. Dropping `tmr_irq_en_i` and raising it again brings the request back.
- R3: The external latch is set only while `ext_irq_en_i` is high. With `pw_mode_i` = 0 it is set on the `ext_rise_i` event (inactive to active). With `pw_mode_i` = 1 it is set on the `ext_fall_i` event (active to inactive). The other edge event has no effect.
- R4: The external latch is cleared at the end of its own service sequence, or whenever `ext_irq_en_i` is low. Re-enabling does not bring back a request that was lost this way.
- R5: `irq_o` is registered. It is high one cycle after the global enable is set, at least one enabled latch is pending and the sequencer is idle. A `gie_set_i` pulse sets the global enable and a `gie_clr_i` pulse clears it. When both are high in the same cycle, clear wins.
- R6: A `grant_i` pulse starts the sequence only while the sequencer is idle and a request is accepted, meaning the global enable is set and an enabled latch is pending. Any other grant leaves `vec_valid_o` and `push_ret_o` low.
- R7: When both the timer and the external latch are pending at the grant, the timer is serviced. The source is captured on the grant cycle, so a request that sets a latch in that same cycle or later does not change the vector in flight.
- R8: Counting from the clock edge that samples `grant_i`, the outputs are as follows. In the first cycle, `vec_valid_o` = 0 and `push_ret_o` = 0 (settling). In the second cycle, `vec_valid_o` = 1, `push_ret_o` = 1 and the low vector byte is driven. In the third cycle, `vec_valid_o` = 1, `push_ret_o` = 0 and the high vector byte is driven. In the fourth cycle, `vec_valid_o` = 0.
- R9: The vector is 11 bits wide: 0x020 for the timer and 0x0A0 for the external source. The low bytes are 0x20 and 0xA0, and the high byte is 0x00 for both.
- R10: At the end of the fourth sequence cycle, the serviced latch and the global enable are cleared. The other latch is left untouched. A new event for the serviced source in that same cycle leaves its latch set.
- R11: After a synchronous reset, both latches and the global enable are clear, and `irq_o`, `vec_valid_o` and `push_ret_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_reload_i | input | 1 | Timer reload event pulse |
| tmr_port_wr_i | input | 1 | Timer port write pulse, clears timer latch |
| ext_rise_i | input | 1 | External pin inactive-to-active event |
| ext_fall_i | input | 1 | External pin active-to-inactive event |
| pw_mode_i | input | 1 | Pulse-width mode: external latch uses the trailing edge |
| tmr_irq_en_i | input | 1 | Local timer interrupt enable |
| ext_irq_en_i | input | 1 | Local external interrupt enable |
| gie_set_i | input | 1 | Set the global interrupt enable |
| gie_clr_i | input | 1 | Clear the global interrupt enable |
| grant_i | input | 1 | CPU grant strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_byte_o | output | 8 | Vector byte |
| vec_valid_o | output | 1 | Vector byte is valid |
| push_ret_o | output | 1 | Save-return-address strobe |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the timer latch's clear at the end of its own service and a fresh timer reload. The bench provokes this by pulsing the reload in exactly the fourth sequence cycle. It then checks that the request comes back once the global enable is set again.

The second pair is the grant and a new timer event. The bench pulses the reload in the grant cycle while only the external latch is pending. A scoreboard queue then checks that the vector bytes still belong to the external source, and that the timer request is serviced afterwards.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_SETTLE = 3'd1,
    SQ_LOW    = 3'd2,
    SQ_HIGH   = 3'd3,
    SQ_CLEAR  = 3'd4
  } seq_state_t;

  typedef enum logic {
    SRC_TMR = 1'b0,
    SRC_EXT = 1'b1
  } irq_src_t;
endpackage

// File: rtl/irqv_req_latches.sv
module irqv_req_latches (
  input  logic clk,
  input  logic rst,
  input  logic tmr_reload_i,
  input  logic tmr_port_wr_i,
  input  logic ext_rise_i,
  input  logic ext_fall_i,
  input  logic pw_mode_i,
  input  logic ext_irq_en_i,
  input  logic ack_tmr_i,
  input  logic ack_ext_i,
  output logic tmr_lat_o,
  output logic ext_lat_o
);
  logic ext_evt;

  // pulse-width mode arms on the trailing edge, all other modes on the leading edge
  assign ext_evt = pw_mode_i ? ext_fall_i : ext_rise_i;

  // timer latch: a new reload outranks any clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                              tmr_lat_o <= 1'b0;
    else if (tmr_reload_i)                tmr_lat_o <= 1'b1;
    else if (ack_tmr_i || tmr_port_wr_i)  tmr_lat_o <= 1'b0;
  end

  // external latch: lives only while its enable is held
  always_ff @(posedge clk) begin
    if (rst)                ext_lat_o <= 1'b0;
    else if (!ext_irq_en_i) ext_lat_o <= 1'b0;
    else if (ext_evt)       ext_lat_o <= 1'b1;
    else if (ack_ext_i)     ext_lat_o <= 1'b0;
  end

  p_tmr_set_r1: assert property (@(posedge clk) disable iff (rst)
    tmr_reload_i |=> tmr_lat_o);
  p_ext_drop_r4: assert property (@(posedge clk) disable iff (rst)
    !ext_irq_en_i |=> !ext_lat_o);
  p_ext_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_lat_o) |-> $past(ext_irq_en_i));
endmodule

// File: rtl/irqv_gie.sv
module irqv_gie (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic seq_clr_i,
  output logic gie_o
);
  always_ff @(posedge clk) begin
    if (rst)                     gie_o <= 1'b0;
    else if (clr_i || seq_clr_i) gie_o <= 1'b0;
    else if (set_i)              gie_o <= 1'b1;
  end

  p_gie_clr_wins_r5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !gie_o);
  p_gie_seq_clr_r10: assert property (@(posedge clk) disable iff (rst)
    seq_clr_i |=> !gie_o);
endmodule

// File: rtl/irqv_sequencer.sv
module irqv_sequencer #(
  parameter int VEC_W = 11,
  parameter logic [VEC_W-1:0] TMR_VEC = 11'h020,
  parameter logic [VEC_W-1:0] EXT_VEC = 11'h0A0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       grant_i,
  input  logic       req_any_i,
  input  logic       tmr_wins_i,
  output logic       idle_o,
  output logic       ack_tmr_o,
  output logic       ack_ext_o,
  output logic [7:0] vec_byte_o,
  output logic       vec_valid_o,
  output logic       push_ret_o
);
  import irqv_pkg::*;

  localparam logic [7:0] TMR_LO = TMR_VEC[7:0];
  localparam logic [7:0] EXT_LO = EXT_VEC[7:0];
  localparam logic [7:0] TMR_HI = 8'(TMR_VEC >> 8);
  localparam logic [7:0] EXT_HI = 8'(EXT_VEC >> 8);

  seq_state_t state_q, state_n;
  irq_src_t   src_q;
  logic       accept;
  logic [7:0] lo_sel, hi_sel;

  assign accept = (state_q == SQ_IDLE) && grant_i && req_any_i;
  assign idle_o = (state_q == SQ_IDLE);
  assign lo_sel = (src_q == SRC_TMR) ? TMR_LO : EXT_LO;
  assign hi_sel = (src_q == SRC_TMR) ? TMR_HI : EXT_HI;
  assign ack_tmr_o = (state_q == SQ_CLEAR) && (src_q == SRC_TMR);
  assign ack_ext_o = (state_q == SQ_CLEAR) && (src_q == SRC_EXT);

  always_comb begin
    state_n = state_q;
    case (state_q)
      SQ_IDLE:   if (accept) state_n = SQ_SETTLE;
      SQ_SETTLE: state_n = SQ_LOW;
      SQ_LOW:    state_n = SQ_HIGH;
      SQ_HIGH:   state_n = SQ_CLEAR;
      SQ_CLEAR:  state_n = SQ_IDLE;
      default:   state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      src_q       <= SRC_TMR;
      vec_valid_o <= 1'b0;
      push_ret_o  <= 1'b0;
      vec_byte_o  <= 8'h00;
    end else begin
      state_q <= state_n;
      if (accept) src_q <= tmr_wins_i ? SRC_TMR : SRC_EXT;
      vec_valid_o <= (state_n == SQ_LOW) || (state_n == SQ_HIGH);
      push_ret_o  <= (state_n == SQ_LOW);
      if (state_n == SQ_LOW)       vec_byte_o <= lo_sel;
      else if (state_n == SQ_HIGH) vec_byte_o <= hi_sel;
      else                         vec_byte_o <= 8'h00;
    end
  end

  p_settle_to_low_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_SETTLE) |=> (vec_valid_o && push_ret_o));
  p_push_then_high_r8: assert property (@(posedge clk) disable iff (rst)
    push_ret_o |=> (vec_valid_o && !push_ret_o));
  p_idle_grant_r6: assert property (@(posedge clk) disable iff (rst)
    (idle_o && grant_i && !req_any_i) |=> idle_o);
  p_one_ack_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_tmr_o, ack_ext_o}));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int VEC_W = 11,
  parameter logic [VEC_W-1:0] TMR_VEC = 11'h020,
  parameter logic [VEC_W-1:0] EXT_VEC = 11'h0A0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tmr_reload_i,
  input  logic       tmr_port_wr_i,
  input  logic       ext_rise_i,
  input  logic       ext_fall_i,
  input  logic       pw_mode_i,
  input  logic       tmr_irq_en_i,
  input  logic       ext_irq_en_i,
  input  logic       gie_set_i,
  input  logic       gie_clr_i,
  input  logic       grant_i,
  output logic       irq_o,
  output logic [7:0] vec_byte_o,
  output logic       vec_valid_o,
  output logic       push_ret_o
);
  logic tmr_lat, ext_lat, gie;
  logic ack_tmr, ack_ext, idle;
  logic pend_tmr, req_any;

  assign pend_tmr = tmr_lat && tmr_irq_en_i;
  assign req_any  = gie && (pend_tmr || ext_lat);

  irqv_req_latches u_lat (
    .clk           (clk),
    .rst           (rst),
    .tmr_reload_i  (tmr_reload_i),
    .tmr_port_wr_i (tmr_port_wr_i),
    .ext_rise_i    (ext_rise_i),
    .ext_fall_i    (ext_fall_i),
    .pw_mode_i     (pw_mode_i),
    .ext_irq_en_i  (ext_irq_en_i),
    .ack_tmr_i     (ack_tmr),
    .ack_ext_i     (ack_ext),
    .tmr_lat_o     (tmr_lat),
    .ext_lat_o     (ext_lat)
  );

  irqv_gie u_gie (
    .clk       (clk),
    .rst       (rst),
    .set_i     (gie_set_i),
    .clr_i     (gie_clr_i),
    .seq_clr_i (ack_tmr || ack_ext),
    .gie_o     (gie)
  );

  irqv_sequencer #(
    .VEC_W   (VEC_W),
    .TMR_VEC (TMR_VEC),
    .EXT_VEC (EXT_VEC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .grant_i     (grant_i),
    .req_any_i   (req_any),
    .tmr_wins_i  (pend_tmr),
    .idle_o      (idle),
    .ack_tmr_o   (ack_tmr),
    .ack_ext_o   (ack_ext),
    .vec_byte_o  (vec_byte_o),
    .vec_valid_o (vec_valid_o),
    .push_ret_o  (push_ret_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= req_any && idle && !grant_i;
  end

  p_irq_needs_gie_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(gie));
  p_push_vector_r9: assert property (@(posedge clk) disable iff (rst)
    push_ret_o |-> (vec_byte_o == TMR_VEC[7:0] || vec_byte_o == EXT_VEC[7:0]));
  p_quiet_in_seq_r8: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> !irq_o);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tmo = 1'b0, twr = 1'b0, rise = 1'b0, fall = 1'b0, pw = 1'b0;
  logic ten = 1'b0, een = 1'b0, gset = 1'b0, gclr = 1'b0, grant = 1'b0;
  logic irq, vvalid, push;
  logic [7:0] vbyte;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] exp_b;

  always #5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst(rst),
    .tmr_reload_i(tmo), .tmr_port_wr_i(twr),
    .ext_rise_i(rise), .ext_fall_i(fall), .pw_mode_i(pw),
    .tmr_irq_en_i(ten), .ext_irq_en_i(een),
    .gie_set_i(gset), .gie_clr_i(gclr), .grant_i(grant),
    .irq_o(irq), .vec_byte_o(vbyte), .vec_valid_o(vvalid), .push_ret_o(push)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // 0 reload, 1 port write, 2 rise, 3 fall, 4 gie set, 5 gie clear
  task automatic pulse(input int which);
    case (which)
      0: tmo = 1'b1; 1: twr = 1'b1; 2: rise = 1'b1;
      3: fall = 1'b1; 4: gset = 1'b1; default: gclr = 1'b1;
    endcase
    step();
    tmo = 1'b0; twr = 1'b0; rise = 1'b0; fall = 1'b0; gset = 1'b0; gclr = 1'b0;
    step();
  endtask

  task automatic chk_irq(input logic e, input string tag);
    chk(irq == e, tag, irq, e);
  endtask

  // grant that must be ignored: no vector activity for four cycles
  task automatic dead_grant(input string tag);
    grant = 1'b1;
    step();
    grant = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!vvalid && !push, tag, {vvalid, push}, 0);
      step();
    end
  endtask

  // driver: queue expected bytes, grant, follow the cycle plan of R8
  // inj 1: reload in grant cycle; inj 2: reload in clear cycle
  task automatic service(input logic [7:0] lo, input int inj);
    exp_q.push_back(lo);
    exp_q.push_back(8'h00);
    grant = 1'b1;
    if (inj == 1) tmo = 1'b1;
    step();
    grant = 1'b0; tmo = 1'b0;
    chk(!vvalid && !push, "R8 settling cycle quiet", {vvalid, push}, 0);
    step();
    chk(vvalid && push, "R8 low byte with push", {vvalid, push}, 3);
    step();
    chk(vvalid && !push, "R8 high byte without push", {vvalid, push}, 2);
    step();
    chk(!vvalid, "R8 clear cycle not valid", vvalid, 0);
    if (inj == 2) tmo = 1'b1;
    step();
    tmo = 1'b0;
    step();
    chk_irq(1'b0, "R10 global enable cleared after service");
  endtask

  // monitor: pop and compare each valid vector byte
  always @(negedge clk) begin
    if (!rst && vvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected vector byte", vbyte, 0);
      end else begin
        exp_b = exp_q.pop_front();
        chk(vbyte == exp_b, "R9 vector byte", vbyte, exp_b);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    chk_irq(1'b0, "R11 reset irq low");
    chk(!vvalid, "R11 reset valid low", vvalid, 0);
    chk(!push, "R11 reset push low", push, 0);
    step();
    chk_irq(1'b0, "R11 global enable clear after reset");

    // R1: the latch records a reload while masked
    pulse(4);
    pulse(0);
    chk_irq(1'b0, "R1 masked timer no request");
    ten = 1'b1; step(); step();
    chk_irq(1'b1, "R1 request after enable");

    // R2: masking keeps the latch; a port write clears it
    ten = 1'b0; step(); step();
    chk_irq(1'b0, "R2 masked again");
    ten = 1'b1; step(); step();
    chk_irq(1'b1, "R2 latch survived masking");
    pulse(1);
    chk_irq(1'b0, "R2 port write clears latch");

    // R3 and R4: external edge selection and enable loss
    een = 1'b1; pw = 1'b0;
    pulse(3);
    chk_irq(1'b0, "R3 trailing edge ignored in normal mode");
    pulse(2);
    chk_irq(1'b1, "R3 leading edge sets latch");
    een = 1'b0; step(); step();
    chk_irq(1'b0, "R4 disable drops external latch");
    een = 1'b1; step(); step();
    chk_irq(1'b0, "R4 re-enable does not restore");
    pw = 1'b1;
    pulse(2);
    chk_irq(1'b0, "R3 leading edge ignored in pulse-width mode");
    pulse(3);
    chk_irq(1'b1, "R3 trailing edge sets latch in pulse-width mode");

    // R5 and R6: global enable
    pulse(5);
    chk_irq(1'b0, "R5 clear removes request");
    dead_grant("R6 grant with global enable clear");
    gset = 1'b1; gclr = 1'b1; step();
    gset = 1'b0; gclr = 1'b0; step();
    chk_irq(1'b0, "R5 clear wins over set");
    pulse(4);
    chk_irq(1'b1, "R5 set restores request");
    een = 1'b0; step(); een = 1'b1; step(); step();
    chk_irq(1'b0, "R4 pending lost before grant");
    dead_grant("R6 grant with nothing pending");

    // R7: both pending, timer first; the external latch survives
    pulse(0);
    pulse(3);
    chk_irq(1'b1, "R7 both pending");
    service(8'h20, 0);
    pulse(4);
    chk_irq(1'b1, "R10 external latch untouched by timer service");

    // R7: reload in grant cycle does not change the vector
    service(8'hA0, 1);
    pulse(4);
    chk_irq(1'b1, "R7 timer from grant cycle kept pending");

    // R10: reload in clear cycle keeps the latch set
    service(8'h20, 2);
    pulse(4);
    chk_irq(1'b1, "R10 reload in clear cycle kept");
    pulse(1);
    chk_irq(1'b0, "R2 port write after service");
    chk(exp_q.size() == 0, "R9 all vector bytes seen", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule